// File: doc/BRIEF.md
# Paged Program Counter Unit

This block holds the instruction address of a small microcontroller core and picks, once per instruction cycle, how that address is loaded. The address is 13 bits wide. The low byte can be written directly, as the target of an ALU result. The upper bits cannot be written directly. They come from a software-written high-bit latch, and the kind of load decides which latch bits are used. A low-byte write takes all five latch bits. A jump or call takes only the two page bits, and the 11-bit opcode field supplies the rest.

A return loads the whole address from the value popped off an external stack, and the latch plays no part. An interrupt vector strobe forces a fixed address. In any other cycle the address advances by one when the increment enable is set, and otherwise it holds. The unit also offers the address of the next instruction, which the core pushes on a call or an interrupt. The stack, the decoder and the program memory are outside this unit.

A computed jump is a low-byte write of the old low byte plus an offset. The carry out of that add is lost. The upper bits come from the latch, so a table that crosses a 256-word boundary needs the latch set up by software.

Top module: `pc_paged_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the address becomes 0x0000 and the high-bit latch becomes 0. This overrides every strobe.
- R2: In a cycle with no load strobe, the address becomes address+1 when `inc_en` is 1, wrapping from 0x1FFF to 0x0000. It holds its value when `inc_en` is 0.
- R3: A low-byte write (`low_we`) loads address bits 7:0 from `low_wdata` and bits 12:8 from latch bits 4:0. A carry from a computed add does not reach bits 12:8.
- R4: A jump or call (`jmp_en`) loads address bits 10:0 from `jmp_addr` and bits 12:11 from latch bits 4:3.
- R5: A return (`ret_en`) loads all 13 address bits from `ret_addr` and leaves the latch unchanged.
- R6: An interrupt vector strobe (`vec_en`) loads the address 0x0004.
- R7: When several strobes are set in one cycle, exactly one takes effect. The order of precedence is vector, then return, then jump, then low-byte write, then increment.
- R8: `push_addr_o` always equals the current address plus one, modulo 8192.
- R9: A latch write (`hl_we`) becomes visible from the next cycle. A load in the same cycle uses the latch value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inc_en | input | 1 | Advance the address by one this cycle |
| low_we | input | 1 | Write the low byte of the address |
| low_wdata | input | 8 | New low byte from the ALU |
| jmp_en | input | 1 | Jump or call strobe |
| jmp_addr | input | 11 | Address field from the opcode |
| ret_en | input | 1 | Return strobe |
| ret_addr | input | 13 | Address popped from the stack |
| vec_en | input | 1 | Interrupt vector strobe |
| hl_we | input | 1 | Write enable for the high-bit latch |
| hl_wdata | input | 5 | New high-bit latch value |
| pc_o | output | 13 | Current instruction address |
| push_addr_o | output | 13 | Next-instruction address to push on a call or interrupt |

## Verification
The bench builds the unit with its default parameters. These are a 13-bit address, an 8-bit low byte, an 11-bit jump field and a vector at 0x0004, so each latch bit width and page split is the real one. With this size the wrap from 0x1FFF to 0x0000 takes only a return to 0x1FFE and two increments. The same address also gives the all-ones page case for jumps and the wrap of the push address. The bench drives chosen latch values, 0x15, 0x0A and 0x18. These expose bits 12:8 and the page bits one by one. The bench also sets strobes in overlapping groups to show the order of precedence.

// File: rtl/pcu_pkg.sv
// Package: shared types for the paged program counter unit.
// Assumes: one load source is chosen per cycle.
package pcu_pkg;

    // Load source for the next instruction address
    typedef enum logic [2:0] {
        SEL_HOLD = 3'd0,
        SEL_INC  = 3'd1,
        SEL_LOW  = 3'd2,
        SEL_JMP  = 3'd3,
        SEL_RET  = 3'd4,
        SEL_VEC  = 3'd5
    } pcu_sel_e;

endpackage

// File: rtl/pcu_hi_latch.sv
// Module: high-bit latch that software writes and that address loads read.
// Assumes: a synchronous active-low reset clears it. Only hl_we changes it.
module pcu_hi_latch #(
    parameter int HI_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [HI_W-1:0] wdata,
    output logic [HI_W-1:0] q
);

    // Purpose: hold the latch value, clear it on reset, load it on a write
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (we)  q <= wdata;
    end

    AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q)); // R5
    AST_LATCH_CLR: assert property (@(posedge clk)
        !rst_n |=> (q == '0)); // R1

endmodule

// File: rtl/pcu_load_arb.sv
// Module: fixed-priority choice of the address load source.
// Assumes: the strobes are valid for the current cycle. Reset is handled by the register.
module pcu_load_arb
    import pcu_pkg::*;
(
    input  logic     vec_en,
    input  logic     ret_en,
    input  logic     jmp_en,
    input  logic     low_we,
    input  logic     inc_en,
    output pcu_sel_e sel
);

    // Purpose: vector over return over jump over low write over increment
    always_comb begin
        if (vec_en)       sel = SEL_VEC;
        else if (ret_en)  sel = SEL_RET;
        else if (jmp_en)  sel = SEL_JMP;
        else if (low_we)  sel = SEL_LOW;
        else if (inc_en)  sel = SEL_INC;
        else              sel = SEL_HOLD;
    end

endmodule

// File: rtl/pcu_next_addr.sv
// Module: forms the next address for the chosen source.
// Assumes: hi is the latch value before any write in this cycle. pc_inc is already wrapped.
module pcu_next_addr
    import pcu_pkg::*;
#(
    parameter int          PC_W     = 13,
    parameter int          LOW_W    = 8,
    parameter int          JMP_W    = 11,
    parameter logic [PC_W-1:0] VEC_ADDR = 13'h0004,
    localparam int         HI_W     = PC_W - LOW_W,
    localparam int         PAGE_W   = PC_W - JMP_W
) (
    input  pcu_sel_e         sel,
    input  logic [PC_W-1:0]  pc_cur,
    input  logic [PC_W-1:0]  pc_inc,
    input  logic [LOW_W-1:0] low_wdata,
    input  logic [JMP_W-1:0] jmp_addr,
    input  logic [PC_W-1:0]  ret_addr,
    input  logic [HI_W-1:0]  hi,
    output logic [PC_W-1:0]  pc_next
);

    logic [PAGE_W-1:0] page_bits;

    // Purpose: take the page bits from the top of the latch
    always_comb page_bits = hi[HI_W-1 -: PAGE_W];

    // Purpose: build the next address from the chosen source
    always_comb begin
        unique case (sel)
            SEL_VEC:  pc_next = VEC_ADDR;
            SEL_RET:  pc_next = ret_addr;
            SEL_JMP:  pc_next = {page_bits, jmp_addr};
            SEL_LOW:  pc_next = {hi, low_wdata};
            SEL_INC:  pc_next = pc_inc;
            default:  pc_next = pc_cur;
        endcase
    end

endmodule

// File: rtl/pc_paged_unit.sv
// Module: top of the paged program counter unit. It holds the address register
// and the high-bit latch, and it offers the push address.
// Assumes: synchronous active-low reset. The return stack lives outside.
module pc_paged_unit
    import pcu_pkg::*;
#(
    parameter int          PC_W     = 13,
    parameter int          LOW_W    = 8,
    parameter int          JMP_W    = 11,
    parameter logic [PC_W-1:0] VEC_ADDR = 13'h0004,
    localparam int         HI_W     = PC_W - LOW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic             low_we,
    input  logic [LOW_W-1:0] low_wdata,
    input  logic             jmp_en,
    input  logic [JMP_W-1:0] jmp_addr,
    input  logic             ret_en,
    input  logic [PC_W-1:0]  ret_addr,
    input  logic             vec_en,
    input  logic             hl_we,
    input  logic [HI_W-1:0]  hl_wdata,
    output logic [PC_W-1:0]  pc_o,
    output logic [PC_W-1:0]  push_addr_o
);

    localparam logic [PC_W-1:0] ONE = {{(PC_W-1){1'b0}}, 1'b1};

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] pc_next;
    logic [HI_W-1:0] hi_q;
    pcu_sel_e        sel;

    // Purpose: address plus one, wrapping at the top of the address space
    always_comb pc_inc = pc_q + ONE;

    pcu_hi_latch #(.HI_W(HI_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (hl_we),
        .wdata (hl_wdata),
        .q     (hi_q)
    );

    pcu_load_arb u_arb (
        .vec_en (vec_en),
        .ret_en (ret_en),
        .jmp_en (jmp_en),
        .low_we (low_we),
        .inc_en (inc_en),
        .sel    (sel)
    );

    pcu_next_addr #(
        .PC_W     (PC_W),
        .LOW_W    (LOW_W),
        .JMP_W    (JMP_W),
        .VEC_ADDR (VEC_ADDR)
    ) u_next (
        .sel       (sel),
        .pc_cur    (pc_q),
        .pc_inc    (pc_inc),
        .low_wdata (low_wdata),
        .jmp_addr  (jmp_addr),
        .ret_addr  (ret_addr),
        .hi        (hi_q),
        .pc_next   (pc_next)
    );

    // Purpose: address register, cleared on reset, otherwise takes the next address
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    // Purpose: drive the outputs
    always_comb begin
        pc_o        = pc_q;
        push_addr_o = pc_inc;
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (pc_o == '0)); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_en && !ret_en && !jmp_en && !low_we && !inc_en) |=> $stable(pc_o)); // R2
    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !vec_en && !ret_en && !jmp_en && !low_we)
        |=> (pc_o == $past(pc_o) + ONE)); // R2
    AST_VEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        vec_en |=> (pc_o == VEC_ADDR)); // R6
    AST_RET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && !vec_en) |=> (pc_o == $past(ret_addr))); // R5
    AST_JMP_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_en && !ret_en && !vec_en)
        |=> (pc_o[JMP_W-1:0] == $past(jmp_addr))); // R4
    AST_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (low_we && !jmp_en && !ret_en && !vec_en)
        |=> (pc_o[LOW_W-1:0] == $past(low_wdata))); // R3

endmodule

// File: tb/pc_paged_unit_tb.sv
`timescale 1ns/100ps
// Bench: directed scenarios for the paged program counter unit, one task each.
module pc_paged_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        inc_en, low_we, jmp_en, ret_en, vec_en, hl_we;
    logic [7:0]  low_wdata;
    logic [10:0] jmp_addr;
    logic [12:0] ret_addr;
    logic [4:0]  hl_wdata;
    logic [12:0] pc_o, push_addr_o;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    logic [4:0] m_hl;   // bench model of the latch

    always #2.5 clk = ~clk;

    pc_paged_unit u_dut (
        .clk(clk), .rst_n(rst_n), .inc_en(inc_en), .low_we(low_we),
        .low_wdata(low_wdata), .jmp_en(jmp_en), .jmp_addr(jmp_addr),
        .ret_en(ret_en), .ret_addr(ret_addr), .vec_en(vec_en),
        .hl_we(hl_we), .hl_wdata(hl_wdata), .pc_o(pc_o), .push_addr_o(push_addr_o)
    );

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<=20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        inc_en = 0; low_we = 0; jmp_en = 0; ret_en = 0; vec_en = 0; hl_we = 0;
        low_wdata = '0; jmp_addr = '0; ret_addr = '0; hl_wdata = '0;
    endtask

    // One clock edge, then back to the falling edge with the strobes cleared
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic set_latch(input logic [4:0] v);
        hl_we = 1; hl_wdata = v; tick(); m_hl = v;
    endtask

    task automatic t_reset();
        rst_n = 0; vec_en = 1; ret_en = 1; ret_addr = 13'h1234; inc_en = 1;
        tick();
        chk("R1 reset clears address", pc_o, 13'h0000);
        rst_n = 1; m_hl = 5'h0;
        low_we = 1; low_wdata = 8'h5A; tick();
        chk("R1 latch zero after reset", pc_o, {5'h00, 8'h5A});
    endtask

    task automatic t_increment();
        tick();
        chk("R2 hold without strobes", pc_o, 13'h005A);
        inc_en = 1; tick();
        chk("R2 increment", pc_o, 13'h005B);
        ret_en = 1; ret_addr = 13'h1FFE; tick();
        inc_en = 1; tick();
        chk("R2 increment to top", pc_o, 13'h1FFF);
        chk("R8 push address wraps", push_addr_o, 13'h0000);
        inc_en = 1; tick();
        chk("R2 increment wraps", pc_o, 13'h0000);
    endtask

    task automatic t_low_write();
        set_latch(5'h15);
        low_we = 1; low_wdata = 8'h3C; tick();
        chk("R3 low write uses latch", pc_o, {m_hl, 8'h3C});
        low_we = 1; low_wdata = 8'h3C + 8'hF0; tick();
        chk("R3 computed add no carry", pc_o, {m_hl, 8'h2C});
    endtask

    task automatic t_latch_timing();
        hl_we = 1; hl_wdata = 5'h0A; low_we = 1; low_wdata = 8'h11; tick();
        chk("R9 same-cycle load uses old latch", pc_o, {5'h15, 8'h11});
        m_hl = 5'h0A;
        low_we = 1; low_wdata = 8'h22; tick();
        chk("R9 latch write visible next cycle", pc_o, {m_hl, 8'h22});
    endtask

    task automatic t_jump();
        jmp_en = 1; jmp_addr = 11'h123; tick();
        chk("R4 jump page 01", pc_o, {m_hl[4:3], 11'h123});
        set_latch(5'h18);
        jmp_en = 1; jmp_addr = 11'h7FF; tick();
        chk("R4 jump page 11", pc_o, 13'h1FFF);
        set_latch(5'h07);
        jmp_en = 1; jmp_addr = 11'h456; tick();
        chk("R4 low latch bits ignored", pc_o, 13'h0456);
    endtask

    task automatic t_return();
        set_latch(5'h0A);
        ret_en = 1; ret_addr = 13'h1ABC; tick();
        chk("R5 return loads popped value", pc_o, 13'h1ABC);
        low_we = 1; low_wdata = 8'h00; tick();
        chk("R5 return leaves latch", pc_o, {5'h0A, 8'h00});
    endtask

    task automatic t_vector();
        vec_en = 1; tick();
        chk("R6 vector address", pc_o, 13'h0004);
        chk("R8 push address next", push_addr_o, 13'h0005);
    endtask

    task automatic t_priority();
        vec_en = 1; ret_en = 1; ret_addr = 13'h0777; jmp_en = 1; jmp_addr = 11'h111;
        low_we = 1; low_wdata = 8'h99; inc_en = 1; tick();
        chk("R7 vector wins", pc_o, 13'h0004);
        ret_en = 1; ret_addr = 13'h0777; jmp_en = 1; jmp_addr = 11'h111;
        low_we = 1; low_wdata = 8'h99; inc_en = 1; tick();
        chk("R7 return over jump", pc_o, 13'h0777);
        jmp_en = 1; jmp_addr = 11'h111; low_we = 1; low_wdata = 8'h99; inc_en = 1; tick();
        chk("R7 jump over low write", pc_o, {m_hl[4:3], 11'h111});
        low_we = 1; low_wdata = 8'h99; inc_en = 1; tick();
        chk("R7 low write over increment", pc_o, {m_hl, 8'h99});
        chk("R8 push after low write", push_addr_o, {m_hl, 8'h9A});
    endtask

    initial begin
        idle();
        rst_n = 0;
        @(negedge clk);
        t_reset();
        t_increment();
        t_low_write();
        t_latch_timing();
        t_jump();
        t_return();
        t_vector();
        t_priority();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule